// File: doc/BRIEF.md
# Adaptive PROM Programming Sequencer

This block runs on the host side of a one-time-programmable byte memory and programs it through the memory's mode/clock/data programming port. The memory has no address pins. It holds an internal address that is zeroed in the clear-address mode and stepped by four clock pulses. The sequencer pulls each byte from an address-indexed source, writes it with 1 ms pulses, and reads it back in verify mode after every pulse. Once a byte verifies, it applies one extra write whose length is the number of attempts times 1 ms, then steps the address.

A session starts with a one-cycle `start_i`. It ends with `done_o` or `err_o` set, and that flag holds until the next start. The millisecond time base comes from the system clock frequency parameter. The supply ramp is not controlled here and is represented only by a settle wait at the start of each session.

Top module: `prom_prog_seq`

## Requirements
- R1: After reset the outputs are `mode_o` = clear (4'b0101), `pclk_o` = 0, `data_oe_o` = 0, `done_o` = 0, `err_o` = 0 and `src_addr_o` = 0. Whenever `done_o` or `err_o` is set, the mode is clear with no clock pulse and no data drive. `mode_o` bit 0..3 drive mode lines 0..3. The encodings are: clear 4'b0101, write 4'b1110, verify 4'b1100, inhibit 4'b1101.
- R2: After `start_i`, the clear mode is held for exactly SETTLE_CYCLES = ceil(SYS_CLK_KHZ*SETTLE_US/1000) cycles (minimum 1). The mode then changes to inhibit. Write mode is never entered directly from clear mode.
- R3: Every write attempt holds write mode for exactly SYS_CLK_KHZ cycles (1 ms) and is followed by inhibit for INH_CYCLES cycles, then by verify mode. `data_oe_o` is high exactly when the mode is write, and `data_o` then carries the source byte of the current address.
- R4: After a mismatching verify, the sequencer starts the next write attempt. The number of attempts spent on a byte equals the number of pulses the memory needs before it reads back correctly.
- R5: After a matching verify, one write of X times SYS_CLK_KHZ cycles follows, where X is the attempt count for that byte. Inhibit follows it.
- R6: The address is advanced by exactly four pulses on `pclk_o`, issued only in inhibit mode. Each high and low phase lasts PH_CYCLES cycles, so a session over N bytes gives exactly 4*N rising edges.
- R7: `src_addr_o` starts at 0 on each session and always equals the memory's internal address during writes. After the last byte (NUM_BYTES-1) the mode returns to clear and `done_o` is set. Both flags are cleared by `start_i`.
- R8: If the byte still mismatches after MAX_TRIES attempts, no over-program write is issued. The mode returns to clear, `err_o` is set, and `err_addr_o` gives the failing address.
- R9: Read-back on `data_i` is compared only in the last of the VFY_CYCLES verify cycles. Values present in earlier verify cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle session start, taken only when idle |
| done_o | output | 1 | Session completed, held until next start |
| err_o | output | 1 | Session aborted on verify failure, held until next start |
| err_addr_o | output | ADDR_W | Address that failed to verify |
| src_addr_o | output | ADDR_W | Index into the byte source |
| src_data_i | input | 8 | Byte at `src_addr_o` |
| mode_o | output | 4 | Programming mode lines |
| pclk_o | output | 1 | Address-step clock to the memory |
| data_o | output | 8 | Write data to the memory bus |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| data_i | input | 8 | Read-back from the memory bus |

## Verification
The assertions assume that the byte source is combinational in `src_addr_o` and stays unchanged for the length of a session, so that `data_o` is stable through a write. They also assume `start_i` arrives only while idle. The bench keeps to both: it fills its byte table and per-address pulse requirements only between sessions, and it raises `start_i` only after a flag is seen. Its memory model returns the inverted byte in every verify cycle except the last. In that last cycle it returns the true byte only once enough write pulses have landed on the address that its own four-pulse counter tracks.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

  typedef enum logic [3:0] {
    MODE_CLEAR   = 4'b0101,
    MODE_WRITE   = 4'b1110,
    MODE_VERIFY  = 4'b1100,
    MODE_INHIBIT = 4'b1101
  } prog_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETTLE,
    S_INH_PRE,
    S_WRITE,
    S_INH_POST,
    S_VERIFY,
    S_OVER,
    S_INH_ADV,
    S_ADV
  } seq_state_e;

endpackage

// File: rtl/prom_ms_tick.sv
module prom_ms_tick #(
  parameter int MS_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MS_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // counter restarts whenever disabled so every pulse is phase aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/prom_clk_burst.sv
module prom_clk_burst #(
  parameter int N_PULSES  = 4,
  parameter int PH_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic pclk_o,
  output logic done_o
);
  localparam int PH_W = $clog2(PH_CYCLES + 1);
  localparam int N_W  = $clog2(N_PULSES + 1);

  logic            active_q, lvl_q;
  logic [PH_W-1:0] ph_q;
  logic [N_W-1:0]  cnt_q;
  logic            last_ph, last_pulse;

  assign last_ph    = (ph_q == PH_W'(PH_CYCLES - 1));
  assign last_pulse = (cnt_q == N_W'(N_PULSES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b0;
      ph_q     <= '0;
      cnt_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      lvl_q    <= 1'b1;
      ph_q     <= '0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (last_ph) begin
        ph_q <= '0;
        if (lvl_q) begin
          lvl_q <= 1'b0;
        end else if (last_pulse) begin
          active_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + N_W'(1);
          lvl_q <= 1'b1;
        end
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  assign pclk_o = lvl_q;
  assign done_o = active_q && !lvl_q && last_ph && last_pulse;
endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_seq_pkg::*;
#(
  parameter int SYS_CLK_KHZ = 250000,
  parameter int SETTLE_US   = 10,
  parameter int ADDR_W      = 13,
  parameter int NUM_BYTES   = 8064,
  parameter int MAX_TRIES   = 20,
  parameter int PH_CYCLES   = 4,
  parameter int INH_CYCLES  = 8,
  parameter int VFY_CYCLES  = 8,
  parameter int CLK_PULSES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [7:0]        src_data_i,
  output logic [3:0]        mode_o,
  output logic              pclk_o,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  input  logic [7:0]        data_i
);
  localparam int MS_CYCLES   = SYS_CLK_KHZ;
  localparam int SETTLE_RAW  = (SYS_CLK_KHZ * SETTLE_US + 999) / 1000;
  localparam int SETTLE_CYC  = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int WAIT_A      = (SETTLE_CYC > INH_CYCLES) ? SETTLE_CYC : INH_CYCLES;
  localparam int WAIT_MAX    = (WAIT_A > VFY_CYCLES) ? WAIT_A : VFY_CYCLES;
  localparam int WAIT_W      = $clog2(WAIT_MAX + 1);
  localparam int TRY_W       = $clog2(MAX_TRIES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

  seq_state_e        state_q, state_d;
  logic [WAIT_W-1:0] wait_q;
  logic [TRY_W-1:0]  tries_q, ms_q;
  logic [ADDR_W-1:0] addr_q, err_addr_q;
  logic              done_q, err_q;
  logic              tick_en, ms_tick, adv_go, adv_done;
  logic              settle_end, inh_end, vfy_end, match;

  prom_ms_tick #(.MS_CYCLES(MS_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .tick_o (ms_tick)
  );

  prom_clk_burst #(.N_PULSES(CLK_PULSES), .PH_CYCLES(PH_CYCLES)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (adv_go),
    .pclk_o (pclk_o),
    .done_o (adv_done)
  );

  assign settle_end = (wait_q == WAIT_W'(SETTLE_CYC - 1));
  assign inh_end    = (wait_q == WAIT_W'(INH_CYCLES - 1));
  assign vfy_end    = (wait_q == WAIT_W'(VFY_CYCLES - 1));
  assign match      = (data_i == src_data_i);
  assign tick_en    = (state_q == S_WRITE) || (state_q == S_OVER);

  always_comb begin
    state_d = state_q;
    adv_go  = 1'b0;
    unique case (state_q)
      S_IDLE:     if (start_i) state_d = S_SETTLE;
      S_SETTLE:   if (settle_end) state_d = S_INH_PRE;
      S_INH_PRE:  if (inh_end) state_d = S_WRITE;
      S_WRITE:    if (ms_tick) state_d = S_INH_POST;
      S_INH_POST: if (inh_end) state_d = S_VERIFY;
      S_VERIFY: begin
        if (vfy_end) begin
          if (match)                             state_d = S_OVER;
          else if (tries_q == TRY_W'(MAX_TRIES)) state_d = S_IDLE;
          else                                   state_d = S_WRITE;
        end
      end
      S_OVER:     if (ms_tick && (ms_q == tries_q - TRY_W'(1))) state_d = S_INH_ADV;
      S_INH_ADV: begin
        if (inh_end) begin
          state_d = S_ADV;
          adv_go  = 1'b1;
        end
      end
      S_ADV:      if (adv_done) state_d = (addr_q == LAST_ADDR) ? S_IDLE : S_WRITE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      wait_q     <= '0;
      tries_q    <= '0;
      ms_q       <= '0;
      addr_q     <= '0;
      err_addr_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)                wait_q <= '0;
      else if (wait_q != WAIT_W'(WAIT_MAX))  wait_q <= wait_q + WAIT_W'(1);

      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
          end
        end
        S_INH_PRE: tries_q <= TRY_W'(1);
        S_VERIFY: begin
          if (vfy_end) begin
            if (match) begin
              ms_q <= '0;
            end else if (tries_q == TRY_W'(MAX_TRIES)) begin
              err_q      <= 1'b1;
              err_addr_q <= addr_q;
            end else begin
              tries_q <= tries_q + TRY_W'(1);
            end
          end
        end
        S_OVER: if (ms_tick) ms_q <= ms_q + TRY_W'(1);
        S_ADV: begin
          if (adv_done) begin
            if (addr_q == LAST_ADDR) begin
              done_q <= 1'b1;
            end else begin
              addr_q  <= addr_q + ADDR_W'(1);
              tries_q <= TRY_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      S_IDLE, S_SETTLE: mode_o = MODE_CLEAR;
      S_WRITE, S_OVER:  mode_o = MODE_WRITE;
      S_VERIFY:         mode_o = MODE_VERIFY;
      default:          mode_o = MODE_INHIBIT;
    endcase
  end

  assign data_oe_o  = tick_en;
  assign data_o     = tick_en ? src_data_i : 8'h00;
  assign src_addr_o = addr_q;
  assign err_addr_o = err_addr_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/prom_prog_seq_chk.sv
module prom_prog_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        mode_o,
  input logic              pclk_o,
  input logic              data_oe_o,
  input logic [7:0]        data_o,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic              done_o,
  input logic              err_o
);
  localparam logic [3:0] M_CLR = 4'b0101;
  localparam logic [3:0] M_WR  = 4'b1110;
  localparam logic [3:0] M_INH = 4'b1101;

  a_r3_oe_only_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (mode_o == M_WR));

  a_r3_data_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

  a_r6_pclk_in_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |-> (mode_o == M_INH));

  a_r2_no_clear_to_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_WR) |-> ($past(mode_o) != M_CLR));

  a_r7_addr_hold_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_WR) && ($past(mode_o) == M_WR)) |-> $stable(src_addr_o));

  a_r1_flags_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> ((mode_o == M_CLR) && !pclk_o && !data_oe_o));

  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

bind prom_prog_seq prom_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_o     (mode_o),
  .pclk_o     (pclk_o),
  .data_oe_o  (data_oe_o),
  .data_o     (data_o),
  .src_addr_o (src_addr_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/prom_prog_seq_tb.sv
module prom_prog_seq_tb;
  localparam int KHZ    = 20;
  localparam int SET_US = 200;
  localparam int AW     = 4;
  localparam int NUM    = 6;
  localparam int MAXT   = 20;
  localparam int PH     = 2;
  localparam int INH    = 3;
  localparam int VFY    = 4;
  localparam int MS     = KHZ;
  localparam int SETC   = ((KHZ * SET_US + 999) / 1000 < 1) ? 1 : (KHZ * SET_US + 999) / 1000;
  localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110, M_VF = 4'b1100, M_INH = 4'b1101;

  logic          clk_i = 0, rst_ni = 0, start_i = 0;
  logic          done_o, err_o, pclk_o, data_oe_o;
  logic [AW-1:0] err_addr_o, src_addr_o;
  logic [7:0]    src_data_i, data_o, data_i, rd_q = 8'h00;
  logic [3:0]    mode_o;

  int total = 0, bad = 0;
  logic [7:0] mem [NUM];
  int need [NUM], attempts [NUM], over_cnt [NUM];
  int dev_addr = 0, rises = 0, run_len = 0, hi_len = 0, vcnt = 0;
  int viol_oe = 0, viol_pclk = 0, cyc = 0;
  logic [3:0] prev_mode = 4'b0101;
  logic prev_pclk = 0, cur_ok = 0, finished = 0;

  always #2 clk_i = ~clk_i;

  assign src_data_i = (int'(src_addr_o) < NUM) ? mem[src_addr_o] : 8'h00;
  assign data_i     = rd_q;

  prom_prog_seq #(
    .SYS_CLK_KHZ(KHZ), .SETTLE_US(SET_US), .ADDR_W(AW), .NUM_BYTES(NUM),
    .MAX_TRIES(MAXT), .PH_CYCLES(PH), .INH_CYCLES(INH), .VFY_CYCLES(VFY), .CLK_PULSES(4)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o), .err_o(err_o),
    .err_addr_o(err_addr_o), .src_addr_o(src_addr_o), .src_data_i(src_data_i),
    .mode_o(mode_o), .pclk_o(pclk_o), .data_o(data_o), .data_oe_o(data_oe_o), .data_i(data_i)
  );

  function automatic void check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endfunction

  function automatic int over_len(input int x);
    return x * MS;
  endfunction

  // memory model and port monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mode_o != prev_mode) begin
        if (prev_mode == M_WR) begin
          if (cur_ok) begin
            if (dev_addr < NUM) begin
              check(run_len == over_len(need[dev_addr]), "R5 over-program width", run_len, over_len(need[dev_addr]));
              over_cnt[dev_addr]++;
            end
            check(mode_o == M_INH, "R5 inhibit after over-program", mode_o, M_INH);
          end else begin
            check(run_len == MS, "R3 write pulse width", run_len, MS);
            check(mode_o == M_INH, "R3 inhibit after write", mode_o, M_INH);
          end
        end
        if (mode_o == M_WR) begin
          check(prev_mode != M_CLR, "R2 write not straight from clear", prev_mode, M_INH);
          check(int'(src_addr_o) == dev_addr, "R7 source address tracks memory", src_addr_o, dev_addr);
          if (dev_addr < NUM) begin
            check(data_o == mem[dev_addr], "R3 write data", data_o, mem[dev_addr]);
            if (!cur_ok) attempts[dev_addr]++;
          end
        end
        if (mode_o == M_VF)  vcnt = 0;
        if (mode_o == M_CLR) begin dev_addr = 0; cur_ok = 0; end
        run_len = 1;
      end else begin
        run_len++;
      end
      if (data_oe_o != (mode_o == M_WR)) viol_oe++;
      if (pclk_o && mode_o != M_INH)     viol_pclk++;
      if (pclk_o && !prev_pclk) begin
        rises++;
        hi_len = 1;
        if (rises % 4 == 0) begin dev_addr++; cur_ok = 0; end
      end else if (pclk_o) begin
        hi_len++;
      end
      if (!pclk_o && prev_pclk) check(hi_len == PH, "R6 clock high phase", hi_len, PH);
      if (mode_o == M_VF && dev_addr < NUM) begin
        // R9: only the last verify cycle carries a correct byte
        if (vcnt == VFY - 1 && attempts[dev_addr] >= need[dev_addr]) begin
          rd_q   = mem[dev_addr];
          cur_ok = 1;
        end else begin
          rd_q = ~mem[dev_addr];
        end
        vcnt++;
      end
      prev_mode = mode_o;
      prev_pclk = pclk_o;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      check(0, "watchdog expired", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_session(input int err_at);
    int cnt, lim;
    for (int a = 0; a < NUM; a++) begin
      mem[a] = 8'($urandom);
      attempts[a] = 0;
      over_cnt[a] = 0;
    end
    rises = 0; viol_oe = 0; viol_pclk = 0;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    check(!done_o && !err_o, "R7 flags cleared by start", {done_o, err_o}, 0);
    cnt = 0;
    while (mode_o != M_INH && cnt < 1000) begin cnt++; @(negedge clk_i); end
    check(cnt == SETC, "R2 settle length in clear", cnt, SETC);
    lim = 0;
    while (!(done_o || err_o) && lim < 60000) begin lim++; @(negedge clk_i); end
    check(lim < 60000, "R7 session finishes", lim, 60000);
    check(mode_o == M_CLR, "R7 clear mode at end", mode_o, M_CLR);
    if (err_at < 0) begin
      check(done_o && !err_o, "R7 done flag", {done_o, err_o}, 2);
      check(rises == 4 * NUM, "R6 four pulses per byte", rises, 4 * NUM);
      for (int a = 0; a < NUM; a++) begin
        check(attempts[a] == need[a], "R4 attempts per byte", attempts[a], need[a]);
        check(over_cnt[a] == 1, "R5 one over-program per byte", over_cnt[a], 1);
      end
    end else begin
      check(err_o && !done_o, "R8 error flag", {done_o, err_o}, 1);
      check(int'(err_addr_o) == err_at, "R8 failing address", err_addr_o, err_at);
      check(attempts[err_at] == MAXT, "R8 attempts before abort", attempts[err_at], MAXT);
      check(over_cnt[err_at] == 0, "R8 no over-program on failure", over_cnt[err_at], 0);
      check(rises == 4 * err_at, "R6 pulses before abort", rises, 4 * err_at);
      for (int a = 0; a < err_at; a++)
        check(attempts[a] == need[a], "R4 attempts before abort", attempts[a], need[a]);
    end
    check(viol_oe == 0, "R3 drive enable only in write", viol_oe, 0);
    check(viol_pclk == 0, "R6 clock only in inhibit", viol_pclk, 0);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd5151));
    for (int a = 0; a < NUM; a++) begin mem[a] = 8'h00; need[a] = 1; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check(mode_o == M_CLR && !pclk_o && !data_oe_o, "R1 reset outputs", {mode_o, pclk_o, data_oe_o}, {M_CLR, 2'b00});
    check(!done_o && !err_o && src_addr_o == 0, "R1 reset flags", {done_o, err_o, src_addr_o}, 0);

    // directed: every byte on first pulse
    run_session(-1);
    // random pulse needs
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < NUM; a++) need[a] = $urandom_range(4, 1);
      run_session(-1);
    end
    // R4/R5 corner: limit attempts, longest over-program
    for (int a = 0; a < NUM; a++) need[a] = $urandom_range(3, 1);
    need[2] = MAXT;
    run_session(-1);
    // R8: never verifies at address 3
    for (int a = 0; a < NUM; a++) need[a] = $urandom_range(3, 1);
    need[3] = MAXT + 1;
    run_session(3);
    // recovery after abort
    for (int a = 0; a < NUM; a++) need[a] = $urandom_range(4, 1);
    run_session(-1);
    // R8 at first and last address
    for (int a = 0; a < NUM; a++) need[a] = 1;
    need[0] = MAXT + 1;
    run_session(0);
    need[0] = 2;
    need[NUM-1] = MAXT + 1;
    run_session(NUM - 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule